// File: doc/BRIEF.md
# Per-Thread Interrupt Priority Presenter

This block sits beside one hardware thread and decides whether that thread should take an interrupt. It holds a bitmap of pending priorities, the priority level the thread is currently running at, a derived "best pending" priority, and a status register. An exception line to the core is raised when something pending is more urgent than the current level. Smaller numbers are more urgent: priority 0 is the most privileged and 7 the least.

Three kinds of stimulus change the state: interrupt arrivals tagged with a 3-bit priority, writes of a new current level, and accept reads with which the core takes the interrupt being signalled. A fourth input ORs bits straight into the pending bitmap without any re-evaluation. After each arrival, level write or accept, the best pending priority is recomputed as the most urgent pending priority capped at the current level. If the result is strictly below the current level, the exception is flagged. All register changes appear one clock after the event. The accept read data is combinational in the cycle of the read.

Top module: `prio_presenter`

## Requirements
- R1: Reset clears the pending bitmap, the status register and `exc_o`, and sets both the current level and the best-pending value to 0, so every interrupt is masked.
- R2: An arrival of priority p sets bit 7-p of the pending bitmap (bit 7 is priority 0, bit 0 is priority 7) one clock later. An arrival on a bit that is already set leaves the bitmap unchanged.
- R3: On an arrival, a level write or an accept, the best-pending value becomes min(L, C) one clock later. L is the most urgent pending priority after the cycle's updates, or 0xFF when nothing is pending. C is the new current level. With no such event the value holds.
- R4: A level write of 0..7 stores that value. A level write above 7 stores 0xFF, which enables every priority.
- R5: An accept while the exception flag is set loads the current level with the best-pending value. It clears that priority's pending bit and clears the flag before the recompute. An accept with the flag clear leaves the level and the bitmap unchanged.
- R6: When a recompute yields a best-pending value strictly below the new current level, status bit 7 (the exception flag) is set and `exc_o` goes high one clock later. The flag and `exc_o` otherwise keep their value until an accept, and `exc_o` always equals status bit 7.
- R7: A direct pending write ORs `force_bits` into the bitmap and does not recompute. When it is the only event in a cycle, the best-pending value, the current level, the status and `exc_o` are unchanged.
- R8: In a cycle with `ack_rd` high, `ack_data` carries the status register in bits [15:8]. Bits [7:0] carry the current level as it will be after the accept: the best-pending value if the flag is set, otherwise the present level.
- R9: Events in the same cycle combine before a single recompute. The accept's bit clear is applied first, then the arrival and the direct write are ORed in. A level write takes precedence over the level load from an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | 1 | Interrupt arrival strobe |
| arr_prio | input | 3 | Priority of the arriving interrupt |
| cppr_wr | input | 1 | Current-level write strobe |
| cppr_wdata | input | 8 | Requested current level |
| force_wr | input | 1 | Direct pending-bit write strobe |
| force_bits | input | 8 | Bits ORed into the pending bitmap |
| ack_rd | input | 1 | Accept read strobe |
| ack_data | output | 16 | Accept read data {status, level after accept} |
| pend_o | output | 8 | Pending bitmap |
| cppr_o | output | 8 | Current level |
| pipr_o | output | 8 | Best pending priority, capped at the current level |
| nsr_o | output | 8 | Status register; bit 7 is the exception flag |
| exc_o | output | 1 | Exception request to the core |

## Verification
A wrong bit in the pending bitmap is visible on `pend_o` at the next clock. It also distorts the best-pending value at the first recompute after it appears. A stale or uncapped best-pending value shows up later, in the exception flag and in the level that the next accept loads. A wrong exception decision is visible on `exc_o` one clock after the triggering event. The bench compares every output against a behavioural model on every clock, so such faults are caught within one cycle of becoming observable.

// File: rtl/prio_presenter.sv
module prio_presenter #(
  parameter int NPRIO = 8,
  parameter int RW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     arr_valid,
  input  logic [$clog2(NPRIO)-1:0] arr_prio,
  input  logic                     cppr_wr,
  input  logic [RW-1:0]            cppr_wdata,
  input  logic                     force_wr,
  input  logic [NPRIO-1:0]         force_bits,
  input  logic                     ack_rd,
  output logic [2*RW-1:0]          ack_data,
  output logic [NPRIO-1:0]         pend_o,
  output logic [RW-1:0]            cppr_o,
  output logic [RW-1:0]            pipr_o,
  output logic [RW-1:0]            nsr_o,
  output logic                     exc_o
);
  localparam logic [RW-1:0] NONE = '1;
  localparam logic [RW-1:0] MAXP = RW'(NPRIO - 1);
  localparam int            EOB  = RW - 1;

  logic [NPRIO-1:0] pend_q, pend_n, clr_m, set_m;
  logic [RW-1:0]    cppr_q, cppr_n, pipr_q, pipr_n, lead, nsr_q, nsr_n;
  logic             exc_q, eo, take, trig, beat;

  assign eo   = nsr_q[EOB];
  assign take = ack_rd & eo;
  assign trig = arr_valid | cppr_wr | ack_rd;

  always_comb begin
    clr_m = '0;
    set_m = '0;
    for (int p = 0; p < NPRIO; p++) begin
      if (take && pipr_q == RW'(p)) clr_m[NPRIO-1-p] = 1'b1;
      if (arr_valid && arr_prio == ($clog2(NPRIO))'(p)) set_m[NPRIO-1-p] = 1'b1;
    end
  end

  assign pend_n = (pend_q & ~clr_m) | set_m | (force_wr ? force_bits : '0);

  always_comb begin
    if (cppr_wr)   cppr_n = (cppr_wdata > MAXP) ? NONE : cppr_wdata;
    else if (take) cppr_n = pipr_q;
    else           cppr_n = cppr_q;
  end

  always_comb begin
    lead = NONE;
    for (int p = NPRIO - 1; p >= 0; p--)
      if (pend_n[NPRIO-1-p]) lead = RW'(p);
  end

  assign pipr_n = (lead < cppr_n) ? lead : cppr_n;
  assign beat   = pipr_n < cppr_n;

  always_comb begin
    nsr_n = nsr_q;
    if (trig) begin
      if (ack_rd) nsr_n[EOB] = 1'b0;
      if (beat)   nsr_n[EOB] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      cppr_q <= '0;
      pipr_q <= '0;
      nsr_q  <= '0;
      exc_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      cppr_q <= cppr_n;
      if (trig) begin
        pipr_q <= pipr_n;
        exc_q  <= nsr_n[EOB];
      end
      nsr_q <= nsr_n;
    end
  end

  assign ack_data = {nsr_q, eo ? pipr_q : cppr_q};
  assign pend_o   = pend_q;
  assign cppr_o   = cppr_q;
  assign pipr_o   = pipr_q;
  assign nsr_o    = nsr_q;
  assign exc_o    = exc_q;

  assert_arrival_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid |=> pend_q[NPRIO-1-$past(arr_prio)]);

  assert_pipr_capped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pipr_q <= cppr_q);

  assert_cppr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_q <= MAXP) || (cppr_q == NONE));

  assert_accept_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && nsr_q[EOB] && !cppr_wr) |=> cppr_q == $past(pipr_q));

  assert_exc_tracks_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o == nsr_o[EOB]);

  assert_force_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (force_wr && !arr_valid && !cppr_wr && !ack_rd) |=>
      ($stable(pipr_q) && $stable(nsr_q) && $stable(cppr_q) && $stable(exc_o)));
endmodule

// File: tb/prio_presenter_bench.sv
module prio_presenter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arr_valid = 1'b0;
  logic [2:0]  arr_prio = '0;
  logic        cppr_wr = 1'b0;
  logic [7:0]  cppr_wdata = '0;
  logic        force_wr = 1'b0;
  logic [7:0]  force_bits = '0;
  logic        ack_rd = 1'b0;
  logic [15:0] ack_data;
  logic [7:0]  pend_o, cppr_o, pipr_o, nsr_o;
  logic        exc_o;

  int vectors = 0;
  int errors  = 0;
  int m_pend, m_cppr, m_pipr, m_nsr;

  always #10 clk = ~clk;

  prio_presenter u_prio_presenter (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_prio(arr_prio),
    .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .force_wr(force_wr),
    .force_bits(force_bits), .ack_rd(ack_rd), .ack_data(ack_data),
    .pend_o(pend_o), .cppr_o(cppr_o), .pipr_o(pipr_o), .nsr_o(nsr_o), .exc_o(exc_o)
  );

  task automatic check(string tag, string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, req, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "R2 pending", pend_o, m_pend);
    check(tag, "R3 pipr", pipr_o, m_pipr);
    check(tag, "R4 cppr", cppr_o, m_cppr);
    check(tag, "R6 status", nsr_o, m_nsr);
    check(tag, "R6 exc", exc_o, (m_nsr >> 7) & 1);
  endtask

  task automatic model_step(bit a, int pr, bit cw, int cd, bit fw, int fb, bit ak);
    int np, nc, ld, npp;
    bit eo;
    eo = (m_nsr & 128) != 0;
    np = m_pend;
    if (ak && eo && m_pipr < 8) np = np & ~(1 << (7 - m_pipr));
    if (a)  np = np | (1 << (7 - pr));
    if (fw) np = np | fb;
    np = np & 255;
    if (cw)            nc = (cd > 7) ? 255 : cd;
    else if (ak && eo) nc = m_pipr;
    else               nc = m_cppr;
    if (a || cw || ak) begin
      ld = 255;
      for (int p = 7; p >= 0; p--) if ((np >> (7 - p)) & 1) ld = p;
      npp = (ld < nc) ? ld : nc;
      m_nsr = (ak ? 0 : m_nsr) | ((npp < nc) ? 128 : 0);
      m_pipr = npp;
    end
    m_pend = np;
    m_cppr = nc;
  endtask

  task automatic cyc(string tag, bit a, int pr, bit cw, int cd, bit fw, int fb, bit ak);
    int exp_ack;
    @(negedge clk);
    compare_all(tag);
    arr_valid = a; arr_prio = 3'(pr); cppr_wr = cw; cppr_wdata = 8'(cd);
    force_wr = fw; force_bits = 8'(fb); ack_rd = ak;
    #1;
    if (ak) begin
      exp_ack = (m_nsr << 8) | (((m_nsr & 128) != 0) ? m_pipr : m_cppr);
      check(tag, "R8 ack_data", ack_data, exp_ack);
    end
    model_step(a, pr, cw, cd, fw, fb, ak);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    m_pend = 0; m_cppr = 0; m_pipr = 0; m_nsr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R1 reset state", 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 arrival masked", 1, 3, 0, 0, 0, 0, 0);
    cyc("R2 arrival merge", 1, 3, 0, 0, 0, 0, 0);
    cyc("R4 level write 5", 0, 0, 1, 5, 0, 0, 0);
    cyc("R6 flag holds", 0, 0, 0, 0, 0, 0, 0);
    cyc("R5 accept with flag", 0, 0, 0, 0, 0, 0, 1);
    cyc("R5 accept without flag", 0, 0, 0, 0, 0, 0, 1);
    cyc("R4 level write 9", 0, 0, 1, 9, 0, 0, 0);
    cyc("R7 direct write only", 0, 0, 0, 0, 1, 8'h20, 0);
    cyc("R7 observe", 0, 0, 0, 0, 0, 0, 0);
    cyc("R3 recompute after direct", 1, 6, 0, 0, 0, 0, 0);
    cyc("R9 arrival with level write", 1, 0, 1, 1, 0, 0, 0);
    cyc("R9 accept with level write", 0, 0, 1, 7, 0, 0, 1);
    cyc("R9 accept with arrival", 1, 2, 0, 0, 1, 8'h01, 1);
    cyc("R5 drain", 0, 0, 0, 0, 0, 0, 1);
    cyc("R5 drain", 0, 0, 0, 0, 0, 0, 1);
    cyc("R4 level write 0xFF", 0, 0, 1, 255, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      cyc("R3 random",
          $urandom_range(0, 9) < 3, $urandom_range(0, 7),
          $urandom_range(0, 9) < 2, (sel < 10) ? 255 : $urandom_range(0, 15),
          $urandom_range(0, 9) < 1, $urandom_range(0, 255),
          $urandom_range(0, 3) == 0);
    end
    cyc("R1 final", 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare_all("final");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule